// File: doc/BRIEF.md
# UART Transmitter with Holding Register

This block is the transmit half of a UART. A CPU-side write port places one character into a single-entry holding register; when the serializer is free and a bit tick arrives, the character moves into a shift register and goes out on the serial line as a start bit, eight data bits least significant first, an optional parity bit and a stop bit. Consecutive characters follow one another with no idle time when the holding register is refilled in time.

Two status flags report progress to software: a ready flag that says the holding register can take a new character, and an empty flag that says both the holding register and the shifter have drained. Enable and disable command pulses gate the whole path. A disable lets the character already in flight finish, but whatever waits in the holding register is thrown away, and writes made while disabled are dropped.

The bit rate is paced by a tick chosen from three sources: a prescaled bus-clock tick, an external tick used directly, or every sixteenth external tick.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset the line `txd` is 1, `txRdy` and `txEmpty` are 0, and the transmitter is disabled.
- R2: An `enCmd` pulse while disabled makes `txRdy` 1 and `txEmpty` 1 on the next cycle (with the shifter idle); `enCmd` while already enabled changes nothing; when `enCmd` and `disCmd` coincide the disable wins.
- R3: A write (`wrEn`) accepted while enabled clears `txRdy` and `txEmpty` on the next cycle.
- R4: A waiting character moves into the shifter on the first selected bit tick at which the shifter is idle or finishing its stop bit; in the cycle after that tick `txd` is 0 (start bit) and `txRdy` is 1.
- R5: A frame is start bit 0, then `wrData` bit 0 through bit 7, then, when `parityEn` is 1, a parity bit equal to the XOR of the data bits XOR `parityOdd` (0 gives even parity, 1 odd), then a stop bit 1; each bit lasts exactly one selected tick period.
- R6: When a character is waiting at the end of a stop bit, the next start bit begins on the same tick, so consecutive frame starts are exactly one frame length apart.
- R7: `txEmpty` rises on the tick that ends a stop bit only if no character is waiting, and stays 0 for as long as a character sits in the holding register or shifter.
- R8: While disabled `txRdy` and `txEmpty` are 0, and a write is ignored: it is never sent, even after a later enable.
- R9: A disable during a frame lets that frame complete, discards the character waiting in the holding register, and clears `txRdy` on the next cycle.
- R10: `clkSel` = 2'b00 takes the bit tick from `busTick`, 2'b01 from every `extTick`, and 2'b10 or 2'b11 from every sixteenth `extTick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busTick | input | 1 | Prescaled bus-clock bit tick, one cycle wide |
| extTick | input | 1 | External clock tick, one cycle wide |
| clkSel | input | 2 | Bit tick source select |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 even |
| enCmd | input | 1 | Enable command pulse |
| disCmd | input | 1 | Disable command pulse |
| wrEn | input | 1 | Holding register write strobe |
| wrData | input | 8 | Character to write |
| txd | output | 1 | Serial output, idles high |
| txRdy | output | 1 | Holding register can accept a character |
| txEmpty | output | 1 | Holding register and shifter both empty |

## Verification
Command and write pulses act on the flags one cycle later, so the bench drives each pulse for one cycle after a falling clock edge and reads the flags on the very next falling edge. The hand-off shows as `txd` falling together with `txRdy` rising in the cycle after a bit tick, and the bench checks both flags at the first falling edge where `txd` reads low. The serial monitor finds each start edge, samples every bit in the middle of its tick period (half a period after the edge, then a whole period apart), pops the expected character from a scoreboard queue and compares data, parity and stop bit; frame spacing is checked by counting cycles between start edges.

// File: rtl/uart_tx_hold_pkg.sv
package uart_tx_hold_pkg;

  // tick source select codes
  localparam logic [1:0] SEL_BUS  = 2'b00;
  localparam logic [1:0] SEL_EXT1 = 2'b01;

  // control-to-datapath strobes
  typedef struct packed {
    logic captureHold;  // load holding register from write port
    logic startFrame;   // move holding register into shifter, emit start bit
    logic advance;      // shift out next bit on this tick
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_hold_dp.sv
module uart_tx_hold_dp
  import uart_tx_hold_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EXT_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busTick,
  input  logic              extTick,
  input  logic [1:0]        clkSel,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         strobe,
  output logic              bitTick,
  output logic              lastBit,
  output logic              txd
);

  localparam int DIV_W   = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam int FRAME_W = DATA_W + 2;
  localparam int REM_W   = $clog2(FRAME_W + 1);

  logic [DIV_W-1:0]   divCnt;
  logic [DATA_W-1:0]  holdData;
  logic [FRAME_W-1:0] frameBits;
  logic [REM_W-1:0]   remaining;
  logic               txdReg;
  logic               parBit;

  // external tick divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (extTick) begin
      divCnt <= (divCnt == DIV_W'(EXT_DIV - 1)) ? '0 : divCnt + 1'b1;
    end
  end

  always_comb begin
    case (clkSel)
      SEL_BUS:  bitTick = busTick;
      SEL_EXT1: bitTick = extTick;
      default:  bitTick = extTick && (divCnt == DIV_W'(EXT_DIV - 1));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData <= '0;
    end else if (strobe.captureHold) begin
      holdData <= wrData;
    end
  end

  assign parBit = (^holdData) ^ parityOdd;

  // shifter: start bit goes straight to the line, the rest waits in frameBits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameBits <= '1;
      remaining <= '0;
      txdReg    <= 1'b1;
    end else if (strobe.startFrame) begin
      frameBits <= {1'b1, (parityEn ? parBit : 1'b1), holdData};
      remaining <= parityEn ? REM_W'(DATA_W + 2) : REM_W'(DATA_W + 1);
      txdReg    <= 1'b0;
    end else if (strobe.advance) begin
      if (remaining == '0) begin
        txdReg <= 1'b1;
      end else begin
        txdReg    <= frameBits[0];
        frameBits <= {1'b1, frameBits[FRAME_W-1:1]};
        remaining <= remaining - 1'b1;
      end
    end
  end

  assign lastBit = (remaining == '0);
  assign txd     = txdReg;

  // R4: a hand-off puts the start bit on the line
  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startFrame |=> !txd);

  // R5: the tick ending the stop bit leaves the line high
  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && lastBit) |=> txd);

endmodule

// File: rtl/uart_tx_hold_ctrl.sv
module uart_tx_hold_ctrl
  import uart_tx_hold_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enCmd,
  input  logic      disCmd,
  input  logic      wrEn,
  input  logic      bitTick,
  input  logic      lastBit,
  output txStrobe_t strobe,
  output logic      txRdy,
  output logic      txEmpty
);

  logic enabled;
  logic holdValid;
  logic busy;
  logic wrAcc;
  logic canLoad;
  logic frameEnd;

  assign wrAcc    = wrEn && enabled && !disCmd;
  assign frameEnd = bitTick && busy && lastBit;
  assign canLoad  = bitTick && enabled && !disCmd && holdValid && (!busy || lastBit);

  always_comb begin
    strobe.captureHold = wrAcc;
    strobe.startFrame  = canLoad;
    strobe.advance     = bitTick && busy && !canLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabled   <= 1'b0;
      holdValid <= 1'b0;
      busy      <= 1'b0;
      txRdy     <= 1'b0;
      txEmpty   <= 1'b0;
    end else begin
      if (canLoad)       busy <= 1'b1;
      else if (frameEnd) busy <= 1'b0;

      if (disCmd) begin
        enabled   <= 1'b0;
        holdValid <= 1'b0;
        txRdy     <= 1'b0;
        txEmpty   <= 1'b0;
      end else if (enCmd && !enabled) begin
        enabled <= 1'b1;
        txRdy   <= 1'b1;
        txEmpty <= !busy || frameEnd;
      end else if (wrAcc) begin
        holdValid <= 1'b1;
        txRdy     <= 1'b0;
        txEmpty   <= 1'b0;
      end else if (canLoad) begin
        holdValid <= 1'b0;
        txRdy     <= 1'b1;
        txEmpty   <= 1'b0;
      end else if (frameEnd && enabled) begin
        txEmpty <= 1'b1;
      end
    end
  end

  // R8: both flags stay low while disabled
  assert_flags_low_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> (!txRdy && !txEmpty));

  // R7: empty never coexists with a character in the holding register or shifter
  assert_empty_means_drained_R7: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> (!busy && !holdValid));

  // R3: an accepted write drops ready next cycle
  assert_write_clears_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureHold |=> !txRdy);

  // R4: the hand-off raises ready unless a write lands in the same cycle
  assert_handoff_sets_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.startFrame && !strobe.captureHold) |=> txRdy);

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_tx_hold_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EXT_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busTick,
  input  logic              extTick,
  input  logic [1:0]        clkSel,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              enCmd,
  input  logic              disCmd,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              txd,
  output logic              txRdy,
  output logic              txEmpty
);

  txStrobe_t strobe;
  logic      bitTick;
  logic      lastBit;

  uart_tx_hold_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enCmd   (enCmd),
    .disCmd  (disCmd),
    .wrEn    (wrEn),
    .bitTick (bitTick),
    .lastBit (lastBit),
    .strobe  (strobe),
    .txRdy   (txRdy),
    .txEmpty (txEmpty)
  );

  uart_tx_hold_dp #(
    .DATA_W  (DATA_W),
    .EXT_DIV (EXT_DIV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .busTick   (busTick),
    .extTick   (extTick),
    .clkSel    (clkSel),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .wrData    (wrData),
    .strobe    (strobe),
    .bitTick   (bitTick),
    .lastBit   (lastBit),
    .txd       (txd)
  );

endmodule

// File: tb/uart_tx_hold_bench.sv
`timescale 1ns/1ps
module uart_tx_hold_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busTick = 1'b0;
  logic       extTick = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       enCmd = 1'b0;
  logic       disCmd = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       txd, txRdy, txEmpty;

  uart_tx_hold u_uart_tx_hold (
    .clk(clk), .rstN(rstN), .busTick(busTick), .extTick(extTick),
    .clkSel(clkSel), .parityEn(parityEn), .parityOdd(parityOdd),
    .enCmd(enCmd), .disCmd(disCmd), .wrEn(wrEn), .wrData(wrData),
    .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // tick generators
  bit tickHold = 1'b1;
  int busP = 4;
  int extP = 3;
  int bitP = 4;  // expected bit period in cycles for the monitor
  int busCnt = 0;
  int extCnt = 0;
  always @(negedge clk) begin
    if (tickHold) begin
      busCnt <= 0; extCnt <= 0; busTick <= 1'b0; extTick <= 1'b0;
    end else begin
      busTick <= (busCnt == busP - 1);
      busCnt  <= (busCnt == busP - 1) ? 0 : busCnt + 1;
      extTick <= (extCnt == extP - 1);
      extCnt  <= (extCnt == extP - 1) ? 0 : extCnt + 1;
    end
  end

  typedef struct {
    logic [7:0] d;
    bit         pOn;
    bit         pOdd;
  } exp_t;
  exp_t expQ[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor
  int rxCount = 0;
  int lastFall = 0;
  int prevFall = 0;
  initial begin
    logic prevLine;
    logic [7:0] got;
    logic pBit, sBit, stBit;
    int p;
    exp_t e;
    prevLine = 1'b1;
    forever begin
      @(negedge clk);
      if (rstN && prevLine && !txd) begin
        p = bitP;
        prevFall = lastFall;
        lastFall = cyc;
        repeat (p / 2) @(negedge clk);
        stBit = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (p) @(negedge clk);
          got[i] = txd;
        end
        if (expQ.size() == 0) begin
          chk(0, "R8 unexpected frame", int'(got), -1);
          e.d = got; e.pOn = 0; e.pOdd = 0;
        end else begin
          e = expQ.pop_front();
        end
        pBit = 1'b1;
        if (e.pOn) begin
          repeat (p) @(negedge clk);
          pBit = txd;
        end
        repeat (p) @(negedge clk);
        sBit = txd;
        rxCount++;
        chk(stBit == 1'b0, "R5 start bit", stBit, 0);
        chk(got == e.d, "R5 data bits", got, e.d);
        if (e.pOn)
          chk(pBit == ((^e.d) ^ e.pOdd), "R5 parity bit", pBit, (^e.d) ^ e.pOdd);
        chk(sBit == 1'b1, "R5 stop bit", sBit, 1);
        prevLine = txd;
      end else begin
        prevLine = txd;
      end
    end
  end

  task automatic pulseEn();
    @(negedge clk) enCmd = 1'b1;
    @(negedge clk) enCmd = 1'b0;
  endtask

  task automatic pulseDis();
    @(negedge clk) disCmd = 1'b1;
    @(negedge clk) disCmd = 1'b0;
  endtask

  task automatic writeChar(input logic [7:0] d, input bit expectSent);
    exp_t e;
    if (expectSent) begin
      e.d = d; e.pOn = parityEn; e.pOdd = parityOdd;
      expQ.push_back(e);
    end
    @(negedge clk) begin wrEn = 1'b1; wrData = d; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic waitTxdLow();
    int n = 0;
    while (txd !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic waitRx(input int target);
    int n = 0;
    while (rxCount < target && n < 20000) begin @(negedge clk); n++; end
    chk(rxCount >= target, "R5 frame count", rxCount, target);
  endtask

  task automatic waitEmpty(input string req);
    int n = 0;
    while (txEmpty !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(txEmpty == 1'b1, req, txEmpty, 1);
    chk(txd == 1'b1, req, txd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    int emptySeen;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(txRdy == 1'b0, "R1 txRdy", txRdy, 0);
    chk(txEmpty == 1'b0, "R1 txEmpty", txEmpty, 0);

    // R8: write while disabled is dropped
    tickHold = 1'b0;
    writeChar(8'h5A, 0);
    chk(txRdy == 1'b0 && txEmpty == 1'b0, "R8 flags while disabled", {txRdy, txEmpty}, 0);
    repeat (100) @(negedge clk);
    chk(txd == 1'b1, "R8 disabled write not sent", txd, 1);
    tickHold = 1'b1;

    // R2: enable
    pulseEn();
    chk(txRdy == 1'b1, "R2 ready on enable", txRdy, 1);
    chk(txEmpty == 1'b1, "R2 empty on enable", txEmpty, 1);

    // R3: write with ticks held
    writeChar(8'h3C, 1);
    chk(txRdy == 1'b0, "R3 ready cleared by write", txRdy, 0);
    chk(txEmpty == 1'b0, "R3 empty cleared by write", txEmpty, 0);
    pulseEn();
    chk(txRdy == 1'b0, "R2 enable while enabled ignored", txRdy, 0);
    // R4: hand-off
    tickHold = 1'b0;
    waitTxdLow();
    chk(txRdy == 1'b1, "R4 ready at hand-off", txRdy, 1);
    chk(txEmpty == 1'b0, "R4 empty low during frame", txEmpty, 0);
    waitRx(1);
    waitEmpty("R7 empty after last stop bit");

    // R5: parity variants
    parityEn = 1'b1; parityOdd = 1'b0;
    writeChar(8'hA7, 1);
    waitRx(2);
    waitEmpty("R5 even parity done");
    parityOdd = 1'b1;
    writeChar(8'h00, 1);
    waitRx(3);
    writeChar(8'hFF, 1);
    waitRx(4);
    waitEmpty("R5 odd parity done");
    parityEn = 1'b0;

    // R6/R7: back-to-back
    base = rxCount;
    writeChar(8'h81, 1);
    while (txRdy !== 1'b1) @(negedge clk);
    writeChar(8'h7E, 1);
    emptySeen = 0;
    while (rxCount < base + 2) begin
      @(negedge clk);
      if (txEmpty) emptySeen++;
    end
    chk(emptySeen == 0, "R7 empty held low while character waits", emptySeen, 0);
    chk(lastFall - prevFall == 10 * bitP, "R6 no gap between frames", lastFall - prevFall, 10 * bitP);
    waitEmpty("R7 empty after pair");

    // R10: external tick used directly
    tickHold = 1'b1;
    clkSel = 2'b01; extP = 3; bitP = 3;
    @(negedge clk);
    tickHold = 1'b0;
    writeChar(8'h96, 1);
    waitRx(base + 3);
    waitEmpty("R10 ext/1 done");

    // R10: external tick divided by sixteen, odd parity
    tickHold = 1'b1;
    clkSel = 2'b10; extP = 1; bitP = 16;
    parityEn = 1'b1; parityOdd = 1'b1;
    @(negedge clk);
    tickHold = 1'b0;
    writeChar(8'h41, 1);
    waitRx(base + 4);
    waitEmpty("R10 ext/16 done");
    parityEn = 1'b0;

    // R9: disable mid-frame with a character pending
    tickHold = 1'b1;
    clkSel = 2'b00; busP = 4; extP = 2; bitP = 4;
    @(negedge clk);
    tickHold = 1'b0;
    base = rxCount;
    writeChar(8'hC3, 1);
    waitTxdLow();
    writeChar(8'h2D, 0);
    chk(txRdy == 1'b0, "R3 ready cleared by pending write", txRdy, 0);
    pulseDis();
    chk(txRdy == 1'b0, "R9 ready cleared by disable", txRdy, 0);
    chk(txEmpty == 1'b0, "R9 empty low after disable", txEmpty, 0);
    repeat (200) @(negedge clk);
    chk(rxCount == base + 1, "R9 current frame completes", rxCount, base + 1);
    chk(txd == 1'b1, "R8 line idle while disabled", txd, 1);
    chk(txEmpty == 1'b0, "R8 empty low while disabled", txEmpty, 0);
    pulseEn();
    chk(txRdy == 1'b1, "R2 ready on re-enable", txRdy, 1);
    chk(txEmpty == 1'b1, "R2 empty on re-enable", txEmpty, 1);
    repeat (200) @(negedge clk);
    chk(rxCount == base + 1, "R9 pending character discarded", rxCount, base + 1);

    // R2: simultaneous enable and disable, disable wins
    @(negedge clk) begin enCmd = 1'b1; disCmd = 1'b1; end
    @(negedge clk) begin enCmd = 1'b0; disCmd = 1'b0; end
    chk(txRdy == 1'b0, "R2 disable wins over enable", txRdy, 0);

    chk(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule